// File: doc/BRIEF.md
# SMRAM and Segment Access Guard

This block decides where each memory access of a host bridge goes when system-management memory is involved. It holds two software-visible control bytes, a window control byte and an extended control byte, together with a 16-bit extended-size register. From them it works out, for every access, whether the legacy low window (0xA0000 to 0xBFFFF), the high alias window (0xFEDA0000 to 0xFEDBFFFF) or a reserved segment at the top of low memory is visible. The answer depends on whether the requester runs in system-management mode (SMM).

Each access is classified into one of three routes: RAM, the PCI/legacy space, or an all-ones sink. The sink answers every read with 0xFFFFFFFF and silently drops every write. A one-way lock bit freezes the configuration until reset. The guard is a decision element only. The memories, the bus fabric and the request widths are handled around it, and the sink treats each access as a full 32-bit little-endian word whatever its byte count.

Top module: `smram_guard`

## Requirements
- R1: After reset the window control byte reads 0x02, the extended control byte reads 0x38, the extended-size register reads 0xFFFF (when the parameter EXT_MB is nonzero), and rspValid is 0. Read-back selects by cfgAddr: 0 = window control byte, 1 = extended control byte, 2 = extended-size register, 3 = zero.
- R2: In the window control byte only bits 6 (open), 4 (lock) and 3 (global enable) are writable. In the extended control byte only bits 7 (high enable), 2:1 (size code) and 0 (segment enable) are writable. Every other bit keeps its value.
- R3: A write that leaves the lock bit (bit 4) set also clears the open bit (bit 6) in that same write. From then until reset no bit of either control byte can change.
- R4: For a non-SMM access to the low window, the route is RAM (0) when open=1 and high enable=0, and PCI (1) otherwise.
- R5: For a non-SMM access to the high alias window, the route is RAM when open=1 and high enable=1, and PCI otherwise.
- R6: With global enable=1, an SMM access goes to RAM for the low window when high enable=0, and for the high window when high enable=1. In every other case an SMM access to a window gets the non-SMM route.
- R7: When segment enable=1, the size code selects the segment size: 0 = 1 MB, 1 = 2 MB, 2 = 8 MB, 3 = EXT_MB megabytes. When segment enable=0 the size is 0 and there is no segment. The segment covers [lowMemSize - size, lowMemSize). There a non-SMM access routes to the sink (2) and an SMM access routes to RAM.
- R8: A sink read returns rspData = 0xFFFFFFFF with rspDrop = 0. A sink write returns rspDrop = 1 and rspData = 0. Every non-sink response carries rspData = 0 and rspDrop = 0.
- R9: An access outside all windows and outside the segment routes to RAM below lowMemSize and to PCI at or above it.
- R10: Writing the query code 0xFFFF to the extended-size register makes it read back EXT_MB. Writing any other value makes it read back that value.
- R11: An access presented on one clock edge produces its response, with rspValid = 1, on the next edge. rspValid is 0 in a cycle that had no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select for write and read-back |
| cfgWrData | input | 16 | Write data (control bytes use bits 7:0) |
| cfgRdData | output | 16 | Read-back of the selected register |
| lowMemSize | input | ADDR_W | Byte size of memory below the 4 GB boundary |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | ADDR_W | Access byte address |
| accSmm | input | 1 | Requester is in system-management mode |
| accWrite | input | 1 | Access is a write |
| rspValid | output | 1 | Registered decision valid |
| rspRoute | output | 2 | 0 = RAM, 1 = PCI/legacy, 2 = sink |
| rspDrop | output | 1 | Write absorbed by the sink |
| rspData | output | 32 | Sink read data (all ones) or zero |

## Verification
The low and high windows are probed under the settings closed, open with high enable 0 and open with high enable 1, from both normal and SMM requesters. This separates the open bit from the high-enable bit, and the normal view from the SMM overlay that global enable adds. Addresses one byte inside and one byte outside each window edge, and each edge of the segment under all four size codes and with the segment disabled, show that every limit and size is decoded exactly. Writes to masked bits, a lock write that also tries to set open, and later writes after lock tell a correct write mask apart from one that is too wide or not frozen. The query-code writes show the extended-size register substituting the configured size only for the query value.

// File: rtl/smram_guard_pkg.sv
package smram_guard_pkg;

  typedef enum logic [1:0] {
    ROUTE_RAM  = 2'd0,
    ROUTE_PCI  = 2'd1,
    ROUTE_SINK = 2'd2
  } route_e;

  localparam int MB_W = 16;

  // window control byte
  localparam int GLOBAL_BIT = 3;
  localparam int LOCK_BIT   = 4;
  localparam int OPEN_BIT   = 6;
  // extended control byte
  localparam int SEG_EN_BIT = 0;
  localparam int SIZE_LSB   = 1;
  localparam int HIGH_BIT   = 7;

  localparam logic [7:0] WIN_RESET       = 8'h02;
  localparam logic [7:0] EXT_RESET       = 8'h38;
  localparam logic [7:0] WIN_MASK_FREE   = 8'h58;
  localparam logic [7:0] EXT_MASK_FREE   = 8'h87;
  localparam logic [7:0] WIN_MASK_LOCKED = 8'h00;
  localparam logic [7:0] EXT_MASK_LOCKED = 8'h00;

  // strobes handed from control to datapath
  typedef struct packed {
    logic            lowNormRam;
    logic            highNormRam;
    logic            lowSmmRam;
    logic            highSmmRam;
    logic [MB_W-1:0] segMb;
  } winStrobe_t;

endpackage

// File: rtl/smram_guard_ctrl.sv
module smram_guard_ctrl
  import smram_guard_pkg::*;
#(
  parameter int          EXT_MB     = 16,
  parameter logic [15:0] QUERY_CODE = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgAddr,
  input  logic [15:0] cfgWrData,
  output logic [15:0] cfgRdData,
  output logic [7:0]  winByte,
  output logic [7:0]  extByte,
  output winStrobe_t  strobe
);

  localparam logic [MB_W-1:0] EXT_MB_L = MB_W'(EXT_MB);

  logic [7:0]  winQ, extQ, winNext, extNext, winMask, extMask;
  logic [15:0] sizeQ, sizeNext, sizeReset;
  logic        locked;

  generate
    if (EXT_MB > 0) begin : g_query
      assign sizeReset = QUERY_CODE;
    end else begin : g_noquery
      assign sizeReset = 16'h0000;
    end
  endgenerate

  assign locked  = winQ[LOCK_BIT];
  assign winMask = locked ? WIN_MASK_LOCKED : WIN_MASK_FREE;
  assign extMask = locked ? EXT_MASK_LOCKED : EXT_MASK_FREE;

  always_comb begin
    winNext = (winQ & ~winMask) | (cfgWrData[7:0] & winMask);
    if (winNext[LOCK_BIT]) winNext[OPEN_BIT] = 1'b0;
    extNext = (extQ & ~extMask) | (cfgWrData[7:0] & extMask);
    sizeNext = cfgWrData;
    if (EXT_MB > 0 && cfgWrData == QUERY_CODE) sizeNext = 16'(EXT_MB_L);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ  <= WIN_RESET;
      extQ  <= EXT_RESET;
      sizeQ <= sizeReset;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        2'd0:    winQ  <= winNext;
        2'd1:    extQ  <= extNext;
        2'd2:    sizeQ <= sizeNext;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfgAddr)
      2'd0:    cfgRdData = {8'h00, winQ};
      2'd1:    cfgRdData = {8'h00, extQ};
      2'd2:    cfgRdData = sizeQ;
      default: cfgRdData = 16'h0000;
    endcase
  end

  logic openOn, highOn, globalOn;
  assign openOn   = winQ[OPEN_BIT];
  assign globalOn = winQ[GLOBAL_BIT];
  assign highOn   = extQ[HIGH_BIT];

  always_comb begin
    strobe.lowNormRam  = openOn & ~highOn;
    strobe.highNormRam = openOn & highOn;
    strobe.lowSmmRam   = globalOn & ~highOn;
    strobe.highSmmRam  = globalOn & highOn;
    if (!extQ[SEG_EN_BIT]) begin
      strobe.segMb = '0;
    end else begin
      case (extQ[SIZE_LSB+:2])
        2'd0:    strobe.segMb = MB_W'(1);
        2'd1:    strobe.segMb = MB_W'(2);
        2'd2:    strobe.segMb = MB_W'(8);
        default: strobe.segMb = EXT_MB_L;
      endcase
    end
  end

  assign winByte = winQ;
  assign extByte = extQ;

endmodule

// File: rtl/smram_guard_path.sv
module smram_guard_path
  import smram_guard_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 'hFEDA_0000,
  parameter logic [ADDR_W-1:0] WIN_BYTES = 'h0002_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lowMemSize,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  input  logic              accWrite,
  output logic              rspValid,
  output logic [1:0]        rspRoute,
  output logic              rspDrop,
  output logic [31:0]       rspData
);

  localparam int SEG_W = MB_W + 20;
  localparam int CMP_W = ((ADDR_W > SEG_W) ? ADDR_W : SEG_W) + 1;
  localparam logic [CMP_W-1:0] LOW_LO  = CMP_W'(LOW_BASE);
  localparam logic [CMP_W-1:0] LOW_HI  = CMP_W'(LOW_BASE) + CMP_W'(WIN_BYTES);
  localparam logic [CMP_W-1:0] HIGH_LO = CMP_W'(HIGH_BASE);
  localparam logic [CMP_W-1:0] HIGH_HI = CMP_W'(HIGH_BASE) + CMP_W'(WIN_BYTES);

  logic [CMP_W-1:0] addrX, lowX, segBytes, segBase;
  logic inSeg, inLow, inHigh;
  route_e route;

  assign addrX    = CMP_W'(accAddr);
  assign lowX     = CMP_W'(lowMemSize);
  assign segBytes = CMP_W'({strobe.segMb, 20'h00000});
  assign segBase  = (lowX >= segBytes) ? (lowX - segBytes) : '0;

  assign inSeg  = (segBytes != '0) && (addrX >= segBase) && (addrX < lowX);
  assign inLow  = (addrX >= LOW_LO) && (addrX < LOW_HI);
  assign inHigh = (addrX >= HIGH_LO) && (addrX < HIGH_HI);

  always_comb begin
    if (inSeg)                                   route = accSmm ? ROUTE_RAM : ROUTE_SINK;
    else if (inLow && accSmm && strobe.lowSmmRam)   route = ROUTE_RAM;
    else if (inHigh && accSmm && strobe.highSmmRam) route = ROUTE_RAM;
    else if (inLow)  route = strobe.lowNormRam  ? ROUTE_RAM : ROUTE_PCI;
    else if (inHigh) route = strobe.highNormRam ? ROUTE_RAM : ROUTE_PCI;
    else             route = (addrX < lowX) ? ROUTE_RAM : ROUTE_PCI;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRoute <= 2'd0;
      rspDrop  <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= accValid;
      rspRoute <= accValid ? route : ROUTE_RAM;
      rspDrop  <= accValid && route == ROUTE_SINK && accWrite;
      rspData  <= (accValid && route == ROUTE_SINK && !accWrite) ? 32'hFFFF_FFFF : 32'h0;
    end
  end

endmodule

// File: rtl/smram_guard.sv
module smram_guard #(
  parameter int          ADDR_W     = 32,
  parameter int          EXT_MB     = 16,
  parameter logic [15:0] QUERY_CODE = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic [ADDR_W-1:0] lowMemSize,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  input  logic              accWrite,
  output logic              rspValid,
  output logic [1:0]        rspRoute,
  output logic              rspDrop,
  output logic [31:0]       rspData
);

  smram_guard_pkg::winStrobe_t strobe;
  logic [7:0] winByte, extByte;

  smram_guard_ctrl #(.EXT_MB(EXT_MB), .QUERY_CODE(QUERY_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .winByte(winByte), .extByte(extByte), .strobe(strobe)
  );

  smram_guard_path #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lowMemSize(lowMemSize),
    .accValid(accValid), .accAddr(accAddr), .accSmm(accSmm), .accWrite(accWrite),
    .rspValid(rspValid), .rspRoute(rspRoute), .rspDrop(rspDrop), .rspData(rspData)
  );

endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accSmm,
  input logic [7:0]  winByte,
  input logic [7:0]  extByte,
  input logic        rspValid,
  input logic [1:0]  rspRoute,
  input logic        rspDrop,
  input logic [31:0] rspData
);

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(winByte[4]) |-> winByte[4]);

  a_r3_locked_not_open: assert property (@(posedge clk) disable iff (!rstN)
    winByte[4] |-> !winByte[6]);

  a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (winByte[4] && $past(winByte[4])) |-> ($stable(winByte) && $stable(extByte)));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);

  a_r7_smm_never_sink: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSmm) |=> rspRoute != 2'd2);

  a_r8_drop_is_sink: assert property (@(posedge clk) disable iff (!rstN)
    rspDrop |-> (rspRoute == 2'd2 && rspData == 32'h0));

  a_r8_sink_read_ones: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRoute == 2'd2 && !rspDrop) |-> rspData == 32'hFFFF_FFFF);

endmodule

bind smram_guard smram_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accSmm(accSmm),
  .winByte(winByte), .extByte(extByte), .rspValid(rspValid),
  .rspRoute(rspRoute), .rspDrop(rspDrop), .rspData(rspData)
);

// File: tb/smram_guard_test.sv
module smram_guard_test;

  localparam int ADDR_W = 32;
  localparam logic [1:0] RAM = 2'd0, PCI = 2'd1, SINK = 2'd2;
  localparam logic [31:0] LOW_MEM = 32'h8000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [15:0] cfgWrData = 16'h0;
  logic [15:0] cfgRdData;
  logic [ADDR_W-1:0] lowMemSize = LOW_MEM;
  logic accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic accSmm = 1'b0;
  logic accWrite = 1'b0;
  logic rspValid, rspDrop;
  logic [1:0] rspRoute;
  logic [31:0] rspData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smram_guard #(.ADDR_W(ADDR_W), .EXT_MB(16)) uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .lowMemSize(lowMemSize),
    .accValid(accValid), .accAddr(accAddr), .accSmm(accSmm), .accWrite(accWrite),
    .rspValid(rspValid), .rspRoute(rspRoute), .rspDrop(rspDrop), .rspData(rspData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input string tag, input logic [1:0] a, input logic [15:0] exp);
    cfgAddr = a;
    #1;
    chk(tag, {16'h0, cfgRdData}, {16'h0, exp});
  endtask

  // access presented for one edge, response sampled at the following negedge
  task automatic probe(input string tag, input logic [31:0] a, input logic smm,
                       input logic wr, input logic [1:0] expRoute);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accSmm = smm; accWrite = wr;
    @(negedge clk);
    accValid = 1'b0; accSmm = 1'b0; accWrite = 1'b0;
    chk({tag, " route"}, {30'h0, rspRoute}, {30'h0, expRoute});
    chk({tag, " valid"}, {31'h0, rspValid}, 32'h1);
    if (expRoute == SINK && !wr) chk({tag, " ones"}, rspData, 32'hFFFF_FFFF);
    else chk({tag, " data"}, rspData, 32'h0);
    chk({tag, " drop"}, {31'h0, rspDrop}, {31'h0, (expRoute == SINK) && wr});
  endtask

  task automatic testReset();
    cfgRead("R1 win reset", 2'd0, 16'h0002);
    cfgRead("R1 ext reset", 2'd1, 16'h0038);
    cfgRead("R1 size reset", 2'd2, 16'hFFFF);
    cfgRead("R1 addr3 zero", 2'd3, 16'h0000);
    chk("R1 rspValid reset", {31'h0, rspValid}, 32'h0);
  endtask

  task automatic testMasks();
    cfgWrite(2'd0, 16'h00EF);
    cfgRead("R2 win mask", 2'd0, 16'h004A);
    cfgWrite(2'd1, 16'h00FF);
    cfgRead("R2 ext mask", 2'd1, 16'h00BF);
    cfgWrite(2'd1, 16'h0000);
    cfgRead("R2 ext clear", 2'd1, 16'h0038);
    cfgWrite(2'd0, 16'h0000);
    cfgRead("R2 win clear", 2'd0, 16'h0002);
  endtask

  task automatic testNormalWindows();
    // closed
    probe("R4 closed low", 32'h000A_0000, 1'b0, 1'b0, PCI);
    probe("R5 closed high", 32'hFEDA_0000, 1'b0, 1'b0, PCI);
    probe("R4 closed low top", 32'h000B_FFFF, 1'b0, 1'b0, PCI);
    probe("R9 below low win", 32'h0009_FFFF, 1'b0, 1'b0, RAM);
    probe("R9 above low win", 32'h000C_0000, 1'b0, 1'b0, RAM);
    // open, high enable 0
    cfgWrite(2'd0, 16'h0040);
    probe("R4 open low", 32'h000A_0000, 1'b0, 1'b0, RAM);
    probe("R5 open hen0 high", 32'hFEDA_0000, 1'b0, 1'b0, PCI);
    // open, high enable 1
    cfgWrite(2'd1, 16'h0080);
    probe("R4 open hen1 low", 32'h000A_0000, 1'b0, 1'b0, PCI);
    probe("R5 open hen1 high", 32'hFEDA_0000, 1'b0, 1'b0, RAM);
    probe("R5 high top", 32'hFEDB_FFFF, 1'b0, 1'b0, RAM);
    probe("R5 past high", 32'hFEDC_0000, 1'b0, 1'b0, PCI);
    probe("R5 before high", 32'hFED9_FFFF, 1'b0, 1'b0, PCI);
    cfgWrite(2'd1, 16'h0000);
    cfgWrite(2'd0, 16'h0000);
  endtask

  task automatic testSmmWindows();
    probe("R6 smm closed low", 32'h000A_0000, 1'b1, 1'b0, PCI);
    cfgWrite(2'd0, 16'h0008);
    probe("R6 smm global low", 32'h000A_0000, 1'b1, 1'b0, RAM);
    probe("R6 smm global hen0 high", 32'hFEDA_0000, 1'b1, 1'b0, PCI);
    probe("R6 normal global low", 32'h000A_0000, 1'b0, 1'b0, PCI);
    cfgWrite(2'd1, 16'h0080);
    probe("R6 smm global hen1 high", 32'hFEDA_0000, 1'b1, 1'b0, RAM);
    probe("R6 smm global hen1 low", 32'h000A_0000, 1'b1, 1'b0, PCI);
    probe("R6 normal hen1 high", 32'hFEDA_0000, 1'b0, 1'b0, PCI);
    cfgWrite(2'd1, 16'h0000);
    cfgWrite(2'd0, 16'h0000);
  endtask

  task automatic testSegment();
    probe("R7 disabled top", 32'h7FFF_FFFC, 1'b0, 1'b0, RAM);
    cfgWrite(2'd1, 16'h0001);
    probe("R7 1MB base", 32'h7FF0_0000, 1'b0, 1'b0, SINK);
    probe("R7 1MB below", 32'h7FEF_FFFF, 1'b0, 1'b0, RAM);
    probe("R8 sink write", 32'h7FFF_FFFC, 1'b0, 1'b1, SINK);
    probe("R7 smm in seg", 32'h7FF0_0000, 1'b1, 1'b0, RAM);
    probe("R9 at low mem", 32'h8000_0000, 1'b0, 1'b0, PCI);
    cfgWrite(2'd1, 16'h0003);
    probe("R7 2MB base", 32'h7FE0_0000, 1'b0, 1'b0, SINK);
    probe("R7 2MB below", 32'h7FDF_FFFF, 1'b0, 1'b0, RAM);
    cfgWrite(2'd1, 16'h0005);
    probe("R7 8MB base", 32'h7F80_0000, 1'b0, 1'b0, SINK);
    probe("R7 8MB below", 32'h7F7F_FFFF, 1'b0, 1'b1, RAM);
    cfgWrite(2'd1, 16'h0007);
    probe("R7 ext base", 32'h7F00_0000, 1'b0, 1'b0, SINK);
    probe("R7 ext below", 32'h7EFF_FFFF, 1'b0, 1'b0, RAM);
    cfgWrite(2'd1, 16'h0006);
    probe("R7 size code no enable", 32'h7FFF_FFFC, 1'b0, 1'b0, RAM);
    cfgWrite(2'd1, 16'h0000);
    probe("R9 low ram", 32'h0000_1000, 1'b0, 1'b0, RAM);
    probe("R9 high pci", 32'h9000_0000, 1'b0, 1'b0, PCI);
  endtask

  task automatic testSizeReg();
    cfgWrite(2'd2, 16'h1234);
    cfgRead("R10 plain value", 2'd2, 16'h1234);
    cfgWrite(2'd2, 16'hFFFF);
    cfgRead("R10 query answer", 2'd2, 16'h0010);
  endtask

  task automatic testLatency();
    probe("R11 first", 32'h0000_2000, 1'b0, 1'b0, RAM);
    @(negedge clk);
    chk("R11 idle after access", {31'h0, rspValid}, 32'h0);
  endtask

  task automatic testLock();
    cfgWrite(2'd0, 16'h0048);
    cfgRead("R3 pre open", 2'd0, 16'h004A);
    cfgWrite(2'd0, 16'h0050);
    cfgRead("R3 lock clears open", 2'd0, 16'h0012);
    cfgWrite(2'd0, 16'h0048);
    cfgRead("R3 win frozen", 2'd0, 16'h0012);
    cfgWrite(2'd1, 16'h00FF);
    cfgRead("R3 ext frozen", 2'd1, 16'h0038);
    probe("R3 locked low closed", 32'h000A_0000, 1'b0, 1'b0, PCI);
    doReset();
    cfgRead("R3 reset unlocks", 2'd0, 16'h0002);
    cfgWrite(2'd0, 16'h0040);
    cfgRead("R3 writable again", 2'd0, 16'h0042);
  endtask

  initial begin
    doReset();
    @(negedge clk);
    testReset();
    testMasks();
    testNormalWindows();
    testSmmWindows();
    testSegment();
    testSizeReg();
    testLatency();
    testLock();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule